// File: doc/BRIEF.md
# Bfloat16 Multiplier Datapath

This block multiplies two 16-bit brain-float operands and returns their 16-bit product. Each word has a sign in bit 15, a biased exponent in bits 14:7 with a bias of 127, and a stored fraction in bits 6:0. Sign, exponent and significand are handled as three separate paths. The sign path is a single XOR. The exponent path adds the two fields and removes the bias with ripple-carry adders, and a carry-lookahead adder applies the later corrections. The significand path restores the hidden one and multiplies the two 8-bit significands in a carry-save array. It then normalizes the result, rounds it to nearest-even with a carry-lookahead incrementer, and drops the hidden one.

The policy for special values is deliberately simple. Subnormal operands count as zero. Results below the normal range flush to a signed zero. Results above the range saturate to a signed infinity. Every NaN output is the single quiet pattern 0x7FC0.

The parameter `STAGES` sets the latency in clock cycles. With zero the block is purely combinational. Registers are first placed at three cut points along the significand path. Beyond three, the extra registers retime the packed result. A new operand pair can enter every cycle, and the valid strobe travels alongside its data.

Top module: `bf16_mul`

## Requirements
- R1: The result sign (bit 15) is the XOR of the two operand signs for numeric, zero and infinite results.
- R2: For two normal operands whose significand product is below 2.0, the result exponent field is the sum of the operand exponent fields minus 127, and the fraction is the rounded product.
- R3: When the 16-bit significand product has its top bit set, the significand is shifted right by one and the exponent is raised by one.
- R4: The normalized significand is rounded to 8 bits by round-to-nearest. An exact tie rounds up only when the kept value is odd.
- R5: When rounding carries the significand to 2.0, it becomes 1.0 and the exponent is raised by one more.
- R6: An operand whose exponent field is 0 is taken as zero whatever its fraction. A finite operand times such a zero gives a zero carrying the XOR sign.
- R7: An operand with exponent field 255 and zero fraction is infinity, and the result is infinity carrying the XOR sign. Infinity times zero gives 0x7FC0.
- R8: An operand with exponent field 255 and a nonzero fraction is NaN, and the result is 0x7FC0.
- R9: A final biased exponent of 255 or more gives signed infinity (exponent field 255, fraction 0).
- R10: A final biased exponent of 0 or below gives signed zero. No output has exponent field 0 with a nonzero fraction.
- R11: `out_res` and `out_valid` follow the inputs after exactly `STAGES` clock cycles, with one new operand pair accepted per cycle. With `STAGES` = 0 the outputs follow the inputs in the same cycle.
- R12: While reset is held low, every pipeline register is cleared, so `out_valid` is low for `STAGES` of at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair valid |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| out_valid | output | 1 | Product valid |
| out_res | output | 16 | Product |

## Verification
The bench builds three copies of the block side by side, with `STAGES` set to 0, 2 and 5, and feeds them the same operand stream. Zero checks the purely combinational chain. Two places the cuts after the multiplier and after rounding, so normalization and rounding share one segment. Five uses all three cuts plus two output retiming registers, so every placement branch and the output chain carry live traffic. Against one reference, this exposes any stage-alignment slip between the sign, exponent and significand paths.

// File: rtl/bf16_mul_pkg.sv
package bf16_mul_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 7;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    // widened exponent holds sums, bias removal and negative values; a multiple of 4 for the CLA
    localparam int XEXP_W = EXP_W + 4;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    localparam logic [EXP_W-1:0]  EXP_ALL1 = '1;
    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        K_NUM  = 2'd0,
        K_ZERO = 2'd1,
        K_INF  = 2'd2,
        K_NAN  = 2'd3
    } kind_e;

    typedef struct packed {
        logic              vld;
        logic              sgn;
        kind_e             kind;
        logic [XEXP_W-1:0] exp;
        logic [PROD_W-1:0] mant;
    } lane_t;

    function automatic kind_e classify(input logic [EXP_W-1:0] e, input logic [FRAC_W-1:0] f);
        if (e == '0)       return K_ZERO;
        if (e == EXP_ALL1) return (f == '0) ? K_INF : K_NAN;
        return K_NUM;
    endfunction

    // cut 1: after the multiplier, cut 2: after normalize, cut 3: after rounding
    function automatic bit cut_enabled(input int stages, input int idx);
        case (idx)
            1:       return stages >= 1;
            2:       return stages >= 3;
            3:       return stages >= 2;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/bf16_rca.sv
module bf16_rca #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W:0] c;
    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ b[i] ^ c[i];
        assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign cout = c[W];
endmodule

// File: rtl/bf16_cla.sv
module bf16_cla #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    timeunit 1ns;
    timeprecision 1ps;

    // W must be a multiple of four: lookahead inside 4-bit groups, groups chained
    localparam int NB = W / 4;

    for (genvar k = 0; k < NB; k++) begin : g_blk
        logic       cin_b;
        logic [3:0] gb;
        logic [3:0] pb;
        logic [4:0] bc;

        if (k == 0) begin : g_first
            assign cin_b = cin;
        end else begin : g_next
            assign cin_b = g_blk[k-1].bc[4];
        end

        assign gb = a[4*k +: 4] & b[4*k +: 4];
        assign pb = a[4*k +: 4] ^ b[4*k +: 4];

        always_comb begin
            bc[0] = cin_b;
            for (int i = 0; i < 4; i++) begin
                logic term;
                logic chain;
                term = 1'b0;
                for (int j = 0; j <= i; j++) begin
                    chain = gb[j];
                    for (int m = j + 1; m <= i; m++) chain = chain & pb[m];
                    term = term | chain;
                end
                chain = cin_b;
                for (int m = 0; m <= i; m++) chain = chain & pb[m];
                bc[i+1] = term | chain;
            end
        end

        assign sum[4*k +: 4] = pb ^ bc[3:0];
    end

    assign cout = g_blk[NB-1].bc[4];
endmodule

// File: rtl/bf16_csa_mul.sv
module bf16_csa_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PW = 2 * W;

    logic [PW-1:0] row_s [0:W];
    logic [PW-1:0] row_c [0:W];
    logic          merge_cout_unused;

    assign row_s[0] = '0;
    assign row_c[0] = '0;

    for (genvar r = 0; r < W; r++) begin : g_row
        logic [PW-1:0] pp;
        assign pp         = b[r] ? (PW'(a) << r) : '0;
        assign row_s[r+1] = row_s[r] ^ row_c[r] ^ pp;
        assign row_c[r+1] = ((row_s[r] & row_c[r]) | (row_s[r] & pp) | (row_c[r] & pp)) << 1;
    end

    bf16_rca #(.W(PW)) u_merge (
        .a   (row_s[W]),
        .b   (row_c[W]),
        .cin (1'b0),
        .sum (p),
        .cout(merge_cout_unused)
    );
endmodule

// File: rtl/bf16_cut.sv
module bf16_cut #(
    parameter int W  = 1,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    timeunit 1ns;
    timeprecision 1ps;

    if (EN) begin : g_reg
        logic [W-1:0] q_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_q <= '0;
            else        q_q <= d;
        end
        assign q = q_q;
    end else begin : g_wire
        logic clk_rst_unused;
        assign clk_rst_unused = clk ^ rst_n;
        assign q = d;
    end
endmodule

// File: rtl/bf16_mul.sv
module bf16_mul
    import bf16_mul_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_res
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LANE_W = $bits(lane_t);
    localparam int EXTRA  = (STAGES > 3) ? STAGES - 3 : 0;
    localparam int SIG_LO = PROD_W - SIG_W;
    localparam logic [XEXP_W-1:0] BIAS_X = XEXP_W'(BIAS);
    localparam logic [XEXP_W-1:0] ONE_X  = XEXP_W'(1);

    // ---------------- segment 0: sign, exponent sum, bias, significand product
    logic [EXP_W-1:0]  ea, eb;
    logic [SIG_W-1:0]  sig_a, sig_b;
    logic [XEXP_W-1:0] esum, eunb;
    logic [PROD_W-1:0] prod;
    logic              eadd_cout_unused, ebias_cout_unused;
    lane_t             ln0_d;

    assign ea    = op_a[WORD_W-2 -: EXP_W];
    assign eb    = op_b[WORD_W-2 -: EXP_W];
    assign sig_a = {1'b1, op_a[FRAC_W-1:0]};
    assign sig_b = {1'b1, op_b[FRAC_W-1:0]};

    bf16_rca #(.W(XEXP_W)) u_eadd (
        .a   ({{(XEXP_W-EXP_W){1'b0}}, ea}),
        .b   ({{(XEXP_W-EXP_W){1'b0}}, eb}),
        .cin (1'b0),
        .sum (esum),
        .cout(eadd_cout_unused)
    );

    bf16_rca #(.W(XEXP_W)) u_ebias (
        .a   (esum),
        .b   (~BIAS_X),
        .cin (1'b1),
        .sum (eunb),
        .cout(ebias_cout_unused)
    );

    bf16_csa_mul #(.W(SIG_W)) u_mul (
        .a(sig_a),
        .b(sig_b),
        .p(prod)
    );

    always_comb begin
        kind_e ka, kb;
        ka = classify(ea, op_a[FRAC_W-1:0]);
        kb = classify(eb, op_b[FRAC_W-1:0]);
        ln0_d      = '0;
        ln0_d.vld  = in_valid;
        ln0_d.sgn  = op_a[WORD_W-1] ^ op_b[WORD_W-1];
        ln0_d.exp  = eunb;
        ln0_d.mant = prod;
        if (ka == K_NAN || kb == K_NAN ||
            (ka == K_INF && kb == K_ZERO) || (ka == K_ZERO && kb == K_INF))
            ln0_d.kind = K_NAN;
        else if (ka == K_INF || kb == K_INF)
            ln0_d.kind = K_INF;
        else if (ka == K_ZERO || kb == K_ZERO)
            ln0_d.kind = K_ZERO;
        else
            ln0_d.kind = K_NUM;
    end

    logic [LANE_W-1:0] c1_q;
    lane_t             ln1_i;
    bf16_cut #(.W(LANE_W), .EN(cut_enabled(STAGES, 1))) u_cut1 (
        .clk(clk), .rst_n(rst_n), .d(ln0_d), .q(c1_q)
    );
    assign ln1_i = lane_t'(c1_q);

    // ---------------- segment 1: normalize and adjust exponent
    logic              top1;
    logic [XEXP_W-1:0] exp_adj;
    logic              adj_cout_unused;
    lane_t             ln1_d;

    assign top1 = ln1_i.mant[PROD_W-1];

    bf16_cla #(.W(XEXP_W)) u_eadj (
        .a   (ln1_i.exp),
        .b   ('0),
        .cin (top1),
        .sum (exp_adj),
        .cout(adj_cout_unused)
    );

    always_comb begin
        ln1_d      = ln1_i;
        ln1_d.exp  = exp_adj;
        ln1_d.mant = top1 ? ln1_i.mant : (ln1_i.mant << 1);
    end

    // R3: a numeric lane leaves normalization with its leading one in place
    p_lead_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ln1_i.vld && ln1_i.kind == K_NUM) |-> ln1_d.mant[PROD_W-1]);

    logic [LANE_W-1:0] c2_q;
    lane_t             ln2_i;
    bf16_cut #(.W(LANE_W), .EN(cut_enabled(STAGES, 2))) u_cut2 (
        .clk(clk), .rst_n(rst_n), .d(ln1_d), .q(c2_q)
    );
    assign ln2_i = lane_t'(c2_q);

    // ---------------- segment 2: round to nearest even
    logic [SIG_W-1:0]  sig_in, sig_inc;
    logic              bit_g, bit_r, bit_s, rnd_up, rnd_carry;
    logic [XEXP_W-1:0] exp_rnd;
    logic              rexp_cout_unused;
    lane_t             ln2_d;

    assign sig_in = ln2_i.mant[PROD_W-1 -: SIG_W];
    assign bit_g  = ln2_i.mant[SIG_LO-1];
    assign bit_r  = ln2_i.mant[SIG_LO-2];
    assign bit_s  = |ln2_i.mant[SIG_LO-3:0];
    assign rnd_up = bit_g & (bit_r | bit_s | sig_in[0]);

    bf16_cla #(.W(SIG_W)) u_rinc (
        .a   (sig_in),
        .b   ('0),
        .cin (rnd_up),
        .sum (sig_inc),
        .cout(rnd_carry)
    );

    bf16_cla #(.W(XEXP_W)) u_rexp (
        .a   (ln2_i.exp),
        .b   ('0),
        .cin (rnd_carry),
        .sum (exp_rnd),
        .cout(rexp_cout_unused)
    );

    always_comb begin
        ln2_d      = ln2_i;
        ln2_d.exp  = exp_rnd;
        ln2_d.mant = '0;
        ln2_d.mant[PROD_W-1 -: SIG_W] = rnd_carry ? {1'b1, {(SIG_W-1){1'b0}}} : sig_inc;
    end

    // R4: rounding moves the kept significand by at most one step
    p_round_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ln2_i.vld && ln2_i.kind == K_NUM) |->
        (ln2_d.mant[PROD_W-1 -: SIG_W] == sig_in ||
         ln2_d.mant[PROD_W-1 -: SIG_W] == sig_in + SIG_W'(1) ||
         (sig_in == '1 && ln2_d.mant[PROD_W-1 -: SIG_W] == {1'b1, {(SIG_W-1){1'b0}}})));

    // R5: the exponent rises only when the significand wrapped to 1.0
    p_round_exp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ln2_i.vld && ln2_i.kind == K_NUM) |->
        (ln2_d.exp == ln2_i.exp ||
         (ln2_d.exp == ln2_i.exp + ONE_X && sig_in == '1)));

    logic [LANE_W-1:0] c3_q;
    lane_t             ln3_i;
    bf16_cut #(.W(LANE_W), .EN(cut_enabled(STAGES, 3))) u_cut3 (
        .clk(clk), .rst_n(rst_n), .d(ln2_d), .q(c3_q)
    );
    assign ln3_i = lane_t'(c3_q);

    // ---------------- segment 3: range check, specials, pack
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] inf_word, zero_word;

    assign inf_word  = {ln3_i.sgn, EXP_ALL1, {FRAC_W{1'b0}}};
    assign zero_word = {ln3_i.sgn, {(EXP_W+FRAC_W){1'b0}}};

    always_comb begin
        case (ln3_i.kind)
            K_NAN:   word_d = QNAN_WORD;
            K_INF:   word_d = inf_word;
            K_ZERO:  word_d = zero_word;
            default: begin
                if ($signed(ln3_i.exp) >= $signed({{(XEXP_W-EXP_W){1'b0}}, EXP_ALL1}))
                    word_d = inf_word;
                else if ($signed(ln3_i.exp) <= 0)
                    word_d = zero_word;
                else
                    word_d = {ln3_i.sgn, ln3_i.exp[EXP_W-1:0], ln3_i.mant[PROD_W-2 -: FRAC_W]};
            end
        endcase
    end

    // ---------------- output retiming beyond the three cuts
    logic [WORD_W:0] tail [0:EXTRA];
    assign tail[0] = {ln3_i.vld, word_d};

    for (genvar i = 0; i < EXTRA; i++) begin : g_tail
        bf16_cut #(.W(WORD_W+1), .EN(1'b1)) u_t (
            .clk(clk), .rst_n(rst_n), .d(tail[i]), .q(tail[i+1])
        );
    end

    assign out_valid = tail[EXTRA][WORD_W];
    assign out_res   = tail[EXTRA][WORD_W-1:0];

    // R10: no output carries a subnormal encoding
    p_no_subnormal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_res[WORD_W-2 -: EXP_W] == '0) |-> (out_res[FRAC_W-1:0] == '0));

    // R8: every NaN that leaves the block is the canonical pattern
    p_nan_canon_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_res[WORD_W-2 -: EXP_W] == EXP_ALL1 && out_res[FRAC_W-1:0] != '0)
        |-> (out_res == QNAN_WORD));
endmodule

// File: tb/tb_bf16_mul.sv
module tb_bf16_mul;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LAT_M = 2;
    localparam int LAT_L = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        v0, vm, vl;
    logic [15:0] r0, rm, rl;

    always #2.5 clk = ~clk;

    bf16_mul #(.STAGES(LAT_L)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(vl), .out_res(rl)
    );
    bf16_mul #(.STAGES(LAT_M)) dut_m (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(vm), .out_res(rm)
    );
    bf16_mul #(.STAGES(0)) dut_c (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(v0), .out_res(r0)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    logic        hv [0:15];
    logic [15:0] hr [0:15];
    string       ht [0:15];

    function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
        int ea, eb, e, p, keep, rem, half;
        bit s, za, zb, ia, ib, na, nb;
        s  = a[15] ^ b[15];
        ea = int'(a[14:7]);
        eb = int'(b[14:7]);
        za = (ea == 0);  zb = (eb == 0);
        ia = (ea == 255) && (a[6:0] == 0);
        ib = (eb == 255) && (b[6:0] == 0);
        na = (ea == 255) && (a[6:0] != 0);
        nb = (eb == 255) && (b[6:0] != 0);
        if (na || nb || (ia && zb) || (ib && za)) return 16'h7FC0;
        if (ia || ib) return {s, 8'hFF, 7'h00};
        if (za || zb) return {s, 15'h0000};
        p = (128 + int'(a[6:0])) * (128 + int'(b[6:0]));
        e = ea + eb - 127;
        if (p >= 32768) begin
            e = e + 1; keep = p / 256; rem = p % 256; half = 128;
        end else begin
            keep = p / 128; rem = p % 128; half = 64;
        end
        if (rem > half || (rem == half && (keep % 2) == 1)) keep = keep + 1;
        if (keep == 256) begin keep = 128; e = e + 1; end
        if (e >= 255) return {s, 8'hFF, 7'h00};
        if (e <= 0) return {s, 15'h0000};
        return {s, 8'(e), 7'(keep - 128)};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic [15:0] b, input logic v,
                        input logic [15:0] e, input string tag);
        int im, il;
        @(posedge clk);
        #1;
        op_a = a; op_b = b; in_valid = v;
        cyc++;
        hv[cyc % 16] = v; hr[cyc % 16] = e; ht[cyc % 16] = tag;
        @(negedge clk);
        check(v0 == v, tag, "comb valid", {15'd0, v0}, {15'd0, v});
        if (v) check(r0 == e, tag, "comb result", r0, e);
        im = (cyc - LAT_M + 16) % 16;
        il = (cyc - LAT_L + 16) % 16;
        check(vm == hv[im], "R11", "stages=2 valid", {15'd0, vm}, {15'd0, hv[im]});
        if (hv[im]) check(rm == hr[im], ht[im], "stages=2 result", rm, hr[im]);
        check(vl == hv[il], "R11", "stages=5 valid", {15'd0, vl}, {15'd0, hv[il]});
        if (hv[il]) check(rl == hr[il], ht[il], "stages=5 result", rl, hr[il]);
    endtask

    task automatic dir(input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] e, input string tag);
        check(ref_mul(a, b) == e, tag, "reference model", ref_mul(a, b), e);
        step(a, b, 1'b1, e, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_unused;
        for (int i = 0; i < 16; i++) begin hv[i] = 1'b0; hr[i] = '0; ht[i] = ""; end
        seed_unused = $urandom(32'd4242);
        in_valid = 1'b1; op_a = 16'h3F80; op_b = 16'h3F80;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R12: registered copies stay cleared under reset despite valid input
        check(vm == 1'b0, "R12", "stages=2 valid in reset", {15'd0, vm}, 16'd0);
        check(vl == 1'b0, "R12", "stages=5 valid in reset", {15'd0, vl}, 16'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        dir(16'h3F80, 16'h3F80, 16'h3F80, "R2");
        dir(16'h4000, 16'h3E80, 16'h3F00, "R2");
        dir(16'hC000, 16'h4040, 16'hC0C0, "R1");
        dir(16'hC000, 16'hC040, 16'h40C0, "R1");
        dir(16'h3FC0, 16'h3FC0, 16'h4010, "R3");
        dir(16'h3F83, 16'h3FC0, 16'h3FC4, "R4");
        dir(16'h3F81, 16'h3FC0, 16'h3FC2, "R4");
        dir(16'h3FB5, 16'h3FB5, 16'h4000, "R5");
        dir(16'h0000, 16'h4040, 16'h0000, "R6");
        dir(16'h8000, 16'h4040, 16'h8000, "R6");
        dir(16'h0001, 16'h4040, 16'h0000, "R6");
        dir(16'h8001, 16'hC040, 16'h0000, "R6");
        dir(16'h7F80, 16'h4000, 16'h7F80, "R7");
        dir(16'h7F80, 16'hC000, 16'hFF80, "R7");
        dir(16'h7F80, 16'h0000, 16'h7FC0, "R7");
        dir(16'hFF80, 16'h8000, 16'h7FC0, "R7");
        dir(16'h7F80, 16'h0005, 16'h7FC0, "R7");
        dir(16'h7FC1, 16'h3F80, 16'h7FC0, "R8");
        dir(16'hFFFF, 16'h0000, 16'h7FC0, "R8");
        dir(16'h3F80, 16'h7F81, 16'h7FC0, "R8");
        dir(16'h7F00, 16'h7F00, 16'h7F80, "R9");
        dir(16'hFF00, 16'h7F00, 16'hFF80, "R9");
        dir(16'h7F00, 16'h4000, 16'h7F80, "R9");
        dir(16'h7F00, 16'h3F80, 16'h7F00, "R9");
        dir(16'h0080, 16'h0080, 16'h0000, "R10");
        dir(16'h8080, 16'h0080, 16'h8000, "R10");
        dir(16'h0080, 16'h3F00, 16'h0000, "R10");
        step(16'h1234, 16'h5678, 1'b0, 16'h0000, "R11");
        step(16'h3F80, 16'h4000, 1'b0, 16'h0000, "R11");

        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a, b;
            logic        v;
            a = 16'($urandom);
            b = 16'($urandom);
            if (($urandom % 4) == 0) begin
                a[14:7] = 8'(8'd100 + 8'($urandom % 56));
                b[14:7] = 8'(8'd100 + 8'($urandom % 56));
            end
            v = (($urandom % 5) != 0);
            step(a, b, v, ref_mul(a, b), "R11");
        end
        for (int n = 0; n < LAT_L + 1; n++) step(16'h0000, 16'h0000, 1'b0, 16'h0000, "R11");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule